// File: doc/BRIEF.md
# Load-Store Byte-Lane Bus Interface

This block sits between the memory stage of a 32-bit load/store pipeline and a memory-mapped bus that uses a wait-request and a read-data-valid signal. It takes one load or store at a time and turns it into a bus cycle. The supported accesses are signed and unsigned byte loads, signed and unsigned halfword loads, word loads, and byte, halfword and word stores. For each access it forms a word-aligned bus address, a four-bit lane enable and, for stores, write data moved into the addressed lane.

On loads the memory may hand back the whole word without regard to the lane enables. The block therefore picks the addressed byte or halfword out of the returned word itself, then sign-extends or zero-extends it. Accesses that are not aligned to their own size are rejected with an error response, and no bus cycle is started.

The request side is a valid/ready handshake. `req_ready` is high only while the block is idle, so a producer holds `req_valid` and its fields until it sees a cycle with both high. Back-pressure from the bus comes through `bus_waitreq`: while it is high the block holds every bus output where it is. The response side is a one-cycle `rsp_valid` pulse that cannot be stalled, and the consumer must take it in that cycle.

Top module: `lsu_lane_bus`

## Requirements
- R1: A byte access (op codes 0 LB, 3 LBU, 5 SB) at address offset 0, 1, 2 or 3 drives `bus_be` to 0001, 0010, 0100 or 1000.
- R2: A halfword access (op codes 1 LH, 4 LHU, 6 SH) drives `bus_be` to 0011 at offset 0 and to 1100 at offset 2.
- R3: A word access (op codes 2 LW, 7 SW) drives `bus_be` to 1111. For every access, `bus_addr` is the request address with bits 1:0 cleared.
- R4: Loads drive the same lane enables as stores of the same size and offset. Loads raise only `bus_read`, and stores raise only `bus_write`.
- R5: Store data goes into the addressed lane. A byte is shifted left by 8 times the offset, and a halfword is shifted left by 16 times address bit 1. Lanes whose enable is 0 are not checked.
- R6: LB and LH return the selected byte or halfword sign-extended to 32 bits, taken from the full returned word.
- R7: LBU and LHU return the selected value zero-extended to 32 bits. LW returns the word unchanged.
- R8: A halfword access with address bit 0 set, or a word access with either of address bits 1:0 set, starts no bus cycle. It answers with `rsp_valid` and `rsp_err` high in the cycle after acceptance.
- R9: While `bus_read` or `bus_write` is high and `bus_waitreq` is high, the strobes, `bus_addr`, `bus_be` and `bus_wdata` keep their values into the next cycle.
- R10: A store answers with `rsp_valid` in the cycle after the bus accepts it (strobe high and `bus_waitreq` low at a clock edge). A load answers in the cycle after `bus_rdvalid` is sampled. `rsp_valid` lasts one cycle, and no strobe is raised after acceptance.
- R11: After synchronous reset the block is idle: `req_ready` is high, and the strobes and `rsp_valid` are low. `req_ready` is low from acceptance until the response has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes the request |
| req_op | input | 3 | Operation code (see R1 to R3) |
| req_addr | input | 32 | Byte effective address |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Address error for the completed request |
| rsp_rdata | output | 32 | Extended load result, 0 for stores and errors |
| bus_addr | output | 32 | Word-aligned bus address |
| bus_be | output | 4 | Lane enables |
| bus_read | output | 1 | Read strobe |
| bus_write | output | 1 | Write strobe |
| bus_wdata | output | 32 | Lane-placed write data |
| bus_waitreq | input | 1 | Bus stall |
| bus_rdata | input | 32 | Returned word |
| bus_rdvalid | input | 1 | Returned word is valid |

## Verification
The bench walks every offset for each size. It loads words whose sign bits sit in every lane, so a lane select that is off by one, or an extension that uses the wrong bit, returns a visibly wrong value. Loads are served with the full word regardless of the enables, so a design that relied on the memory to mask would fail. Random wait-request bursts and random read latencies catch bus outputs that move during a stall, responses that arrive one cycle early or late, and strobes raised again after acceptance. Misaligned halfword and word requests at every bad offset check that a design issues no bus cycle and still reports the error on time.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [2:0] {
    OP_LB  = 3'd0,
    OP_LH  = 3'd1,
    OP_LW  = 3'd2,
    OP_LBU = 3'd3,
    OP_LHU = 3'd4,
    OP_SB  = 3'd5,
    OP_SH  = 3'd6,
    OP_SW  = 3'd7
  } lsu_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } lsu_size_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_RESP  = 2'd3
  } lsu_state_e;

  function automatic lsu_size_e op_size(lsu_op_e op);
    case (op)
      OP_LB, OP_LBU, OP_SB: op_size = SZ_BYTE;
      OP_LH, OP_LHU, OP_SH: op_size = SZ_HALF;
      default:              op_size = SZ_WORD;
    endcase
  endfunction

  function automatic logic op_store(lsu_op_e op);
    op_store = (op == OP_SB) || (op == OP_SH) || (op == OP_SW);
  endfunction

  function automatic logic op_signed(lsu_op_e op);
    op_signed = (op == OP_LB) || (op == OP_LH);
  endfunction

  // ofs_any: some offset bit set; ofs_b0: lowest offset bit set
  function automatic logic size_misaligned(lsu_size_e sz, logic ofs_any, logic ofs_b0);
    case (sz)
      SZ_HALF: size_misaligned = ofs_b0;
      SZ_WORD: size_misaligned = ofs_any;
      default: size_misaligned = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lsu_lane_enc.sv
module lsu_lane_enc
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  lsu_op_e             op,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W/8-1:0] be,
  output logic [DATA_W-1:0]   wdata_lane
);
  localparam int BE_W  = DATA_W / 8;
  localparam int OFS_W = $clog2(BE_W);

  logic [OFS_W-1:0] ofs;
  lsu_size_e        sz;

  assign ofs = addr[OFS_W-1:0];
  assign sz  = op_size(op);

  // drop the lane bits: the bus only sees whole words
  assign bus_addr = {addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

  always_comb begin
    case (sz)
      SZ_BYTE: be = BE_W'(1) << ofs;
      SZ_HALF: be = BE_W'(3) << ofs;
      default: be = {BE_W{1'b1}};
    endcase
  end

  // aligned halfwords have ofs[0]==0, so one byte-granular shift serves both sizes
  assign wdata_lane = wdata << {ofs, 3'b000};

endmodule

// File: rtl/lsu_read_ext.sv
module lsu_read_ext
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  lsu_op_e                     op,
  input  logic [$clog2(DATA_W/8)-1:0] ofs,
  input  logic [DATA_W-1:0]           word,
  output logic [DATA_W-1:0]           result
);
  localparam int BE_W  = DATA_W / 8;
  localparam int OFS_W = $clog2(BE_W);

  logic [7:0]       lane [BE_W];
  logic [OFS_W-1:0] ofs_hi;
  logic [7:0]       byte_v;
  logic [15:0]      half_v;
  logic             sext;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign lane[g] = word[8*g +: 8];
  end

  // halfwords are aligned, so the upper byte sits at ofs with bit 0 set
  assign ofs_hi = ofs | OFS_W'(1);
  assign byte_v = lane[ofs];
  assign half_v = {lane[ofs_hi], lane[ofs]};
  assign sext   = op_signed(op);

  always_comb begin
    case (op_size(op))
      SZ_BYTE: result = {{(DATA_W-8){sext & byte_v[7]}}, byte_v};
      SZ_HALF: result = {{(DATA_W-16){sext & half_v[15]}}, half_v};
      default: result = word;
    endcase
  end

endmodule

// File: rtl/lsu_bus_seq.sv
module lsu_bus_seq
  import lsu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_err,
  input  logic is_store,
  input  logic waitreq,
  input  logic rdvalid,
  output logic ready,
  output logic rd,
  output logic wr,
  output logic rsp,
  output logic capture
);
  lsu_state_e st, st_n;

  always_ff @(posedge clk) begin
    if (rst) st <= S_IDLE;
    else     st <= st_n;
  end

  always_comb begin
    st_n    = st;
    ready   = 1'b0;
    rd      = 1'b0;
    wr      = 1'b0;
    rsp     = 1'b0;
    capture = 1'b0;
    case (st)
      S_IDLE: begin
        ready = 1'b1;
        if (start) st_n = start_err ? S_RESP : S_ISSUE;
      end
      S_ISSUE: begin
        wr = is_store;
        rd = !is_store;
        if (!waitreq) st_n = is_store ? S_RESP : S_WAIT;
      end
      S_WAIT: begin
        if (rdvalid) begin
          capture = 1'b1;
          st_n    = S_RESP;
        end
      end
      default: begin
        rsp  = 1'b1;
        st_n = S_IDLE;
      end
    endcase
  end

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp |=> !rsp);

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(rd && wr));

  a_r9_strobe_held: assert property (@(posedge clk) disable iff (rst)
    (rd || wr) && waitreq |=> (rd || wr) && $stable(rd) && $stable(wr));

  a_r10_no_restrobe: assert property (@(posedge clk) disable iff (rst)
    (rd || wr) && !waitreq |=> !(rd || wr));

  a_r11_busy: assert property (@(posedge clk) disable iff (rst)
    start && ready |=> !ready);

endmodule

// File: rtl/lsu_lane_bus.sv
module lsu_lane_bus
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [2:0]          req_op,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W/8-1:0] bus_be,
  output logic                bus_read,
  output logic                bus_write,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_waitreq,
  input  logic [DATA_W-1:0]   bus_rdata,
  input  logic                bus_rdvalid
);
  localparam int BE_W  = DATA_W / 8;
  localparam int OFS_W = $clog2(BE_W);

  lsu_op_e           in_op, op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, ext_val;
  logic              err_q;
  logic [OFS_W-1:0]  in_ofs;
  logic              in_err, accept, capture;

  assign in_op  = lsu_op_e'(req_op);
  assign in_ofs = req_addr[OFS_W-1:0];
  assign in_err = size_misaligned(op_size(in_op), |in_ofs, in_ofs[0]);
  assign accept = req_valid && req_ready;

  // request is held in flops for the whole bus cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= OP_LW;
      addr_q  <= '0;
      wdata_q <= '0;
      err_q   <= 1'b0;
    end else if (accept) begin
      op_q    <= in_op;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      err_q   <= in_err;
    end
  end

  lsu_lane_enc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_enc (
    .op         (op_q),
    .addr       (addr_q),
    .wdata      (wdata_q),
    .bus_addr   (bus_addr),
    .be         (bus_be),
    .wdata_lane (bus_wdata)
  );

  lsu_read_ext #(.DATA_W(DATA_W)) u_ext (
    .op     (op_q),
    .ofs    (addr_q[OFS_W-1:0]),
    .word   (bus_rdata),
    .result (ext_val)
  );

  lsu_bus_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (req_valid),
    .start_err (in_err),
    .is_store  (op_store(op_q)),
    .waitreq   (bus_waitreq),
    .rdvalid   (bus_rdvalid),
    .ready     (req_ready),
    .rd        (bus_read),
    .wr        (bus_write),
    .rsp       (rsp_valid),
    .capture   (capture)
  );

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (accept)  rdata_q <= '0;
    else if (capture) rdata_q <= ext_val;
  end

  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;

  a_r9_bus_held: assert property (@(posedge clk) disable iff (rst)
    (bus_read || bus_write) && bus_waitreq |=>
      $stable(bus_addr) && $stable(bus_be) && $stable(bus_wdata));

  a_r8_err_quiet: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_err |-> $past(!bus_read && !bus_write));

  a_r1_byte_lane: assert property (@(posedge clk) disable iff (rst)
    (bus_read || bus_write) && op_size(op_q) == SZ_BYTE |-> $onehot(bus_be));

  a_r2_half_lanes: assert property (@(posedge clk) disable iff (rst)
    (bus_read || bus_write) && op_size(op_q) == SZ_HALF |-> $countones(bus_be) == 2);

  a_r10_load_after_valid: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_err && !op_store(op_q) |-> $past(bus_rdvalid));

  a_r6_byte_sign: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_err && op_q == OP_LB |->
      rsp_rdata[DATA_W-1:8] == {(DATA_W-8){rsp_rdata[7]}});

  a_r7_byte_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_err && op_q == OP_LBU |-> rsp_rdata[DATA_W-1:8] == '0);

endmodule

// File: tb/lsu_lane_bus_tb.sv
`timescale 1ns/1ps
module lsu_lane_bus_tb;
  import lsu_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [31:0] bus_addr;
  logic [3:0]  bus_be;
  logic        bus_read, bus_write;
  logic [31:0] bus_wdata;
  logic        bus_waitreq = 1'b1;
  logic [31:0] bus_rdata = '0;
  logic        bus_rdvalid = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [31:0] mem [16];

  always #2.5 clk = ~clk;

  lsu_lane_bus u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_read(bus_read),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_waitreq(bus_waitreq),
    .bus_rdata(bus_rdata), .bus_rdvalid(bus_rdvalid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_be(lsu_op_e op, logic [1:0] ofs);
    case (op_size(op))
      SZ_BYTE: exp_be = 4'b0001 << ofs;
      SZ_HALF: exp_be = ofs[1] ? 4'b1100 : 4'b0011;
      default: exp_be = 4'b1111;
    endcase
  endfunction

  function automatic logic exp_mis(lsu_op_e op, logic [1:0] ofs);
    case (op_size(op))
      SZ_HALF: exp_mis = ofs[0];
      SZ_WORD: exp_mis = (ofs != 2'd0);
      default: exp_mis = 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_load(lsu_op_e op, logic [1:0] ofs, logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[8*ofs +: 8];
    h = ofs[1] ? w[31:16] : w[15:0];
    case (op)
      OP_LB:   exp_load = {{24{b[7]}}, b};
      OP_LBU:  exp_load = {24'd0, b};
      OP_LH:   exp_load = {{16{h[15]}}, h};
      OP_LHU:  exp_load = {16'd0, h};
      default: exp_load = w;
    endcase
  endfunction

  function automatic logic [31:0] exp_lane(lsu_op_e op, logic [1:0] ofs, logic [31:0] d);
    case (op_size(op))
      SZ_BYTE: exp_lane = {24'd0, d[7:0]} << (8*ofs);
      SZ_HALF: exp_lane = {16'd0, d[15:0]} << (16*ofs[1]);
      default: exp_lane = d;
    endcase
  endfunction

  function automatic string size_req(lsu_op_e op);
    case (op_size(op))
      SZ_BYTE: size_req = "R1";
      SZ_HALF: size_req = "R2";
      default: size_req = "R3";
    endcase
  endfunction

  task automatic run_op(input lsu_op_e op, input logic [31:0] a, input logic [31:0] wd,
                        input int waits, input int lat);
    bit st, mis, seen, acc_prev, acc_now, rdv_prev, rdv_now, done, acc_done, prev_wait;
    logic [1:0]  ofs;
    logic [3:0]  eb, pbe;
    logic [31:0] el, paddr, pwd;
    int          lat_cnt, cnt, w;
    st = op_store(op); ofs = a[1:0]; mis = exp_mis(op, ofs);
    eb = exp_be(op, ofs); el = exp_lane(op, ofs, wd);
    seen = 0; acc_prev = 0; rdv_prev = 0; done = 0; acc_done = 0; prev_wait = 0;
    lat_cnt = 0; cnt = 0; w = waits; pbe = '0; paddr = '0; pwd = '0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10", "pulse longer than one cycle", 32'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R11", "not ready when idle", 32'(req_ready), 1);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
    bus_waitreq = 1'b1; bus_rdvalid = 1'b0;
    while (!done && cnt < 60) begin
      @(negedge clk);
      cnt++;
      req_valid = 1'b0;
      acc_now = 0; rdv_now = 0;
      if (cnt == 1) chk(req_ready == 1'b0, "R11", "ready while busy", 32'(req_ready), 0);
      if (rsp_valid) begin
        if (mis) chk(cnt == 1 && !seen, "R8", "error response timing", cnt, 1);
        else if (st) chk(acc_prev, "R10", "store response timing", cnt, 0);
        else chk(rdv_prev, "R10", "load response timing", cnt, 0);
        chk(rsp_err == mis, "R8", "error flag", 32'(rsp_err), 32'(mis));
        if (!mis && !st)
          chk(rsp_rdata == exp_load(op, ofs, mem[a[5:2]]),
              op_signed(op) ? "R6" : "R7", "load result",
              rsp_rdata, exp_load(op, ofs, mem[a[5:2]]));
        done = 1; bus_rdvalid = 1'b0; bus_waitreq = 1'b1;
      end else begin
        if ((mis && cnt == 1) || (st && acc_prev) || rdv_prev)
          chk(0, "R10", "missing response", cnt, 0);
        if (bus_read || bus_write) begin
          if (mis) chk(0, "R8", "strobe on misaligned request", bus_addr, a);
          if (acc_done) chk(0, "R10", "strobe after acceptance", bus_addr, a);
          if (!seen) begin
            chk(bus_addr == {a[31:2], 2'b00}, "R3", "bus address", bus_addr, {a[31:2], 2'b00});
            chk(bus_be == eb, size_req(op), st ? "store enables" : "R4 load enables", 32'(bus_be), 32'(eb));
            chk(bus_write == st && bus_read == !st, "R4", "strobe direction",
                {bus_read, bus_write}, {!st, st});
            if (st)
              for (int i = 0; i < 4; i++)
                if (eb[i]) chk(bus_wdata[8*i +: 8] == el[8*i +: 8], "R5", "store lane data",
                               bus_wdata, el);
            seen = 1;
          end else if (prev_wait) begin
            chk(bus_addr == paddr && bus_be == pbe && bus_wdata == pwd, "R9",
                "bus changed under wait", bus_addr, paddr);
          end
          paddr = bus_addr; pbe = bus_be; pwd = bus_wdata;
          if (w > 0) begin
            w--; bus_waitreq = 1'b1; prev_wait = 1;
          end else begin
            bus_waitreq = 1'b0; prev_wait = 0; acc_now = 1; acc_done = 1;
            if (st) begin
              for (int i = 0; i < 4; i++)
                if (bus_be[i]) mem[a[5:2]][8*i +: 8] = bus_wdata[8*i +: 8];
            end else lat_cnt = lat;
          end
        end else begin
          if (prev_wait) chk(0, "R9", "strobe dropped under wait", 0, 1);
          bus_waitreq = 1'($urandom % 2); prev_wait = 0;
        end
        if (lat_cnt > 0 && !acc_now) begin
          lat_cnt--;
          if (lat_cnt == 0) begin
            bus_rdvalid = 1'b1; bus_rdata = mem[a[5:2]]; rdv_now = 1;
          end else begin
            bus_rdvalid = 1'b0; bus_rdata = $urandom;
          end
        end else begin
          bus_rdvalid = 1'b0; bus_rdata = $urandom;
        end
      end
      acc_prev = acc_now; rdv_prev = rdv_now;
    end
    if (!done) chk(0, "R10", "no response", cnt, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < 16; i++) mem[i] = $urandom;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(req_ready && !bus_read && !bus_write && !rsp_valid, "R11", "reset state",
        {req_ready, bus_read, bus_write, rsp_valid}, 4'b1000);

    // words with sign bits placed in different lanes
    run_op(OP_SW, 32'h1000_0000, 32'h80FF_7F01, 0, 1);
    run_op(OP_SW, 32'h1000_0004, 32'h7F80_01FF, 2, 1);
    for (int k = 0; k < 2; k++)
      for (int o = 0; o < 4; o++) begin
        run_op(OP_LB,  32'h1000_0000 + 4*k + o, 0, o % 2, 1 + o % 3);
        run_op(OP_LBU, 32'h1000_0000 + 4*k + o, 0, 0, 2);
        run_op(OP_LH,  32'h1000_0000 + 4*k + o, 0, 1, 1);
        run_op(OP_LHU, 32'h1000_0000 + 4*k + o, 0, 0, 3);
        run_op(OP_LW,  32'h1000_0000 + 4*k + o, 0, 3, 2);
      end
    for (int o = 0; o < 4; o++) begin
      run_op(OP_SB, 32'h2000_0008 + o, 32'hA5A5_A500 | o, o, 1);
      run_op(OP_SH, 32'h2000_000C + o, 32'h1234_8765, 1, 1);
      run_op(OP_SW, 32'h2000_0010 + o, 32'hDEAD_BEEF, 0, 1);
      run_op(OP_LW, 32'h2000_0008, 0, 0, 1);
      run_op(OP_LW, 32'h2000_000C, 0, 0, 1);
    end

    for (int n = 0; n < 500; n++)
      run_op(lsu_op_e'($urandom % 8), $urandom, $urandom, $urandom % 4, 1 + $urandom % 3);

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule